// File: doc/BRIEF.md
# Mask First-Set Prefix Unit

This unit turns a packed source mask into a packed destination mask whose pattern depends on where the first active set element lies. One scan over every element position serves three operations: mark the elements before the first active set element, mark those up to and including it, or mark only that element. Each element owns a slot of `MLEN` bits in the packed registers. Only the lowest bit of a slot is read or written. The other bits of the slot come from the old destination unchanged.

Activity follows the usual vector masking rule. With `vm_i` high every element is active. With `vm_i` low, an element is active only when its bit in the enable mask is set. An inactive element keeps its old destination bit, and the search for the first set bit skips it. A start strobe launches the operation. The result is registered and appears with a one-cycle `done_o` pulse. A nonzero start index or an unknown operation code raises `illegal_o` and returns the old destination unchanged.

Top module: `mask_first_set`

## Requirements
- R1: The 5-bit `op_sel_i` selects the operation: 1 is set-before-first, 2 is set-only-first, 3 is set-including-first. Any other code raises `illegal_o` with `done_o` and returns `old_dst_i` unchanged as the result.
- R2: Set-before-first writes 1 to each active element that comes before the first active element with source bit 1. It writes 0 to that element and to every active element after it.
- R3: Set-including-first writes 1 to each active element up to and including the first active set element, and 0 to every active element after it.
- R4: Set-only-first writes 1 only at the first active set element and 0 at every other active element, so at most one element bit is 1.
- R5: An element is active when `vm_i` is 1, or when `vm_i` is 0 and the enable-mask bit of its slot is 1. An inactive element keeps its `old_dst_i` bit, and its source bit is ignored when the first set element is located.
- R6: Element i is bit `MLEN*i` of every packed mask. Every other bit of the result equals the corresponding `old_dst_i` bit.
- R7: The scan covers all `VLMAX` element positions, up to and including the last one.
- R8: A nonzero `vstart_i` raises `illegal_o` with `done_o` and returns `old_dst_i` unchanged.
- R9: When no active element has its source bit set, set-before-first and set-including-first make every active element 1, and set-only-first makes every active element 0.
- R10: `done_o` pulses high exactly one cycle after `start_i` and is low otherwise. The result and `illegal_o` are registered and hold until the next start. Reset clears `result_o`, `done_o` and `illegal_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launch strobe; operands are sampled in this cycle |
| op_sel_i | input | 5 | Operation code (1 before-first, 2 only-first, 3 including-first) |
| vm_i | input | 1 | 1: all elements active; 0: enable mask decides |
| vstart_i | input | VSTART_W | Start element index; must be 0 for a legal operation |
| src_mask_i | input | VLMAX*MLEN | Packed source mask |
| en_mask_i | input | VLMAX*MLEN | Packed enable mask |
| old_dst_i | input | VLMAX*MLEN | Previous destination value |
| result_o | output | VLMAX*MLEN | Registered destination value |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | Operation rejected (start index or code) |

## Verification
The assertions check on every cycle that:
- `done_o` trails `start_i` by exactly one cycle.
- A rejected operation returns the old destination.
- The non-element bits of each slot and the bits of inactive elements come through from the old destination.
- The scan never produces more than one first-set flag.

Only the bench's scenarios can show the prefix patterns themselves. These include where the boundary lands relative to the first active set element and the masked-off set bits that must be skipped. They also include the all-clear case, a set bit only in the last position, and the behaviour of each code, compared against an independent element loop over tabled and random masks.

// File: rtl/mfs_pkg.sv
package mfs_pkg;

  typedef enum logic [4:0] {
    MFS_BEFORE = 5'd1,
    MFS_ONLY   = 5'd2,
    MFS_INCL   = 5'd3
  } mfs_op_e;

  function automatic logic mfs_code_known(input logic [4:0] code);
    return (code == MFS_BEFORE) || (code == MFS_ONLY) || (code == MFS_INCL);
  endfunction

endpackage

// File: rtl/mfs_extract.sv
module mfs_extract #(
  parameter int VLMAX = 16,
  parameter int MLEN  = 2,
  localparam int MASK_W = VLMAX * MLEN
) (
  input  logic [MASK_W-1:0] src_mask_i,
  input  logic [MASK_W-1:0] en_mask_i,
  input  logic              vm_i,
  output logic [VLMAX-1:0]  src_bits_o,
  output logic [VLMAX-1:0]  act_bits_o
);

  logic unused_slot_bits;
  assign unused_slot_bits = ^{src_mask_i, en_mask_i};

  for (genvar e = 0; e < VLMAX; e++) begin : g_elem
    assign src_bits_o[e] = src_mask_i[MLEN*e];
    assign act_bits_o[e] = vm_i | en_mask_i[MLEN*e];
  end

endmodule

// File: rtl/mfs_scan.sv
module mfs_scan #(
  parameter int VLMAX = 16
) (
  input  logic [VLMAX-1:0] src_bits_i,
  input  logic [VLMAX-1:0] act_bits_i,
  output logic [VLMAX-1:0] before_o,
  output logic [VLMAX-1:0] incl_o,
  output logic [VLMAX-1:0] only_o
);

  logic [VLMAX:0]   clear_upto;
  logic [VLMAX-1:0] hit;

  assign clear_upto[0] = 1'b1;

  for (genvar e = 0; e < VLMAX; e++) begin : g_chain
    assign hit[e]          = src_bits_i[e] & act_bits_i[e];
    assign clear_upto[e+1] = clear_upto[e] & ~hit[e];
    assign before_o[e]     = clear_upto[e+1];
    assign incl_o[e]       = clear_upto[e];
    assign only_o[e]       = clear_upto[e] & hit[e];
  end

  always_comb begin
    a_r4_single_first: assert ($onehot0(only_o));
  end

endmodule

// File: rtl/mfs_merge.sv
module mfs_merge #(
  parameter int VLMAX = 16,
  parameter int MLEN  = 2,
  localparam int MASK_W = VLMAX * MLEN
) (
  input  logic [MASK_W-1:0] old_dst_i,
  input  logic [VLMAX-1:0]  new_bits_i,
  input  logic [VLMAX-1:0]  act_bits_i,
  output logic [MASK_W-1:0] merged_o
);

  for (genvar e = 0; e < VLMAX; e++) begin : g_slot
    assign merged_o[MLEN*e] = act_bits_i[e] ? new_bits_i[e] : old_dst_i[MLEN*e];
    if (MLEN > 1) begin : g_upper
      assign merged_o[MLEN*e+MLEN-1 : MLEN*e+1] = old_dst_i[MLEN*e+MLEN-1 : MLEN*e+1];
    end
  end

endmodule

// File: rtl/mask_first_set.sv
module mask_first_set
  import mfs_pkg::*;
#(
  parameter int VLMAX    = 16,
  parameter int MLEN     = 2,
  parameter int VSTART_W = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [4:0]              op_sel_i,
  input  logic                    vm_i,
  input  logic [VSTART_W-1:0]     vstart_i,
  input  logic [VLMAX*MLEN-1:0]   src_mask_i,
  input  logic [VLMAX*MLEN-1:0]   en_mask_i,
  input  logic [VLMAX*MLEN-1:0]   old_dst_i,
  output logic [VLMAX*MLEN-1:0]   result_o,
  output logic                    done_o,
  output logic                    illegal_o
);

  localparam int MASK_W = VLMAX * MLEN;

  function automatic logic [MASK_W-1:0] lsb_pattern();
    logic [MASK_W-1:0] p;
    p = '0;
    for (int e = 0; e < VLMAX; e++) p[MLEN*e] = 1'b1;
    return p;
  endfunction

  localparam logic [MASK_W-1:0] LSB_MASK = lsb_pattern();

  logic [VLMAX-1:0]  src_bits, act_bits;
  logic [VLMAX-1:0]  pat_before, pat_incl, pat_only, pat_sel;
  logic [MASK_W-1:0] merged, next_dst;
  logic              op_ok, start_ok, req_legal;

  mfs_extract #(.VLMAX(VLMAX), .MLEN(MLEN)) u_extract (
    .src_mask_i (src_mask_i),
    .en_mask_i  (en_mask_i),
    .vm_i       (vm_i),
    .src_bits_o (src_bits),
    .act_bits_o (act_bits)
  );

  mfs_scan #(.VLMAX(VLMAX)) u_scan (
    .src_bits_i (src_bits),
    .act_bits_i (act_bits),
    .before_o   (pat_before),
    .incl_o     (pat_incl),
    .only_o     (pat_only)
  );

  always_comb begin
    case (op_sel_i)
      MFS_BEFORE: pat_sel = pat_before;
      MFS_ONLY:   pat_sel = pat_only;
      MFS_INCL:   pat_sel = pat_incl;
      default:    pat_sel = '0;
    endcase
  end

  mfs_merge #(.VLMAX(VLMAX), .MLEN(MLEN)) u_merge (
    .old_dst_i  (old_dst_i),
    .new_bits_i (pat_sel),
    .act_bits_i (act_bits),
    .merged_o   (merged)
  );

  assign op_ok     = mfs_code_known(op_sel_i);
  assign start_ok  = (vstart_i == '0);
  assign req_legal = op_ok & start_ok;
  assign next_dst  = req_legal ? merged : old_dst_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_o  <= '0;
      done_o    <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      done_o <= start_i;
      if (start_i) begin
        result_o  <= next_dst;
        illegal_o <= ~req_legal;
      end
    end
  end

  a_r10_done_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
    done_o == $past(start_i));

  a_r8_reject_keeps_old: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && illegal_o) |-> (result_o == $past(old_dst_i)));

  a_r6_slot_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ((result_o & ~LSB_MASK) == ($past(old_dst_i) & ~LSB_MASK)));

  for (genvar e = 0; e < VLMAX; e++) begin : g_chk
    a_r5_inactive_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !$past(act_bits[e])) |-> (result_o[MLEN*e] == $past(old_dst_i[MLEN*e])));
  end

endmodule

// File: tb/tb_mask_first_set.sv
module tb_mask_first_set;

  localparam int VLMAX = 16;
  localparam int MLEN  = 2;
  localparam int MW    = VLMAX * MLEN;
  localparam int NVEC  = 8;

  typedef struct packed {
    logic [4:0]    op;
    logic          vm;
    logic [MW-1:0] src;
    logic [MW-1:0] en;
    logic [MW-1:0] old;
  } vec_t;

  localparam vec_t TBL [NVEC] = '{
    '{5'd1, 1'b1, 32'h0000_0040, 32'h0000_0000, 32'hAAAA_AAAA},
    '{5'd3, 1'b1, 32'h0000_0040, 32'h0000_0000, 32'hAAAA_AAAA},
    '{5'd2, 1'b1, 32'h0000_0040, 32'h0000_0000, 32'hAAAA_AAAA},
    '{5'd1, 1'b0, 32'h0001_0011, 32'h5555_0050, 32'h0F0F_0F0F},
    '{5'd3, 1'b0, 32'h1000_0005, 32'h1010_1010, 32'hFFFF_0000},
    '{5'd2, 1'b0, 32'h0505_0505, 32'h5A5A_5A5A, 32'h3333_3333},
    '{5'd2, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000},
    '{5'd1, 1'b1, 32'h0000_0001, 32'hFFFF_FFFF, 32'h5555_5555}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [4:0]    op_sel_i = '0;
  logic          vm_i = 1'b0;
  logic [6:0]    vstart_i = '0;
  logic [MW-1:0] src_mask_i = '0;
  logic [MW-1:0] en_mask_i = '0;
  logic [MW-1:0] old_dst_i = '0;
  logic [MW-1:0] result_o;
  logic          done_o, illegal_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  mask_first_set #(.VLMAX(VLMAX), .MLEN(MLEN), .VSTART_W(7)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_sel_i(op_sel_i),
    .vm_i(vm_i), .vstart_i(vstart_i), .src_mask_i(src_mask_i),
    .en_mask_i(en_mask_i), .old_dst_i(old_dst_i), .result_o(result_o),
    .done_o(done_o), .illegal_o(illegal_o)
  );

  function automatic logic [MW-1:0] ref_dst(input logic [4:0] op, input logic vm,
      input logic [MW-1:0] src, input logic [MW-1:0] en, input logic [MW-1:0] old);
    logic [MW-1:0] r;
    logic seen, s;
    int p;
    r = old;
    seen = 1'b0;
    if (op < 5'd1 || op > 5'd3) return old;
    for (int e = 0; e < VLMAX; e++) begin
      p = e * MLEN;
      s = src[p];
      if (vm || en[p]) begin
        if (op == 5'd1) r[p] = !seen && !s;
        else if (op == 5'd2) r[p] = !seen && s;
        else r[p] = !seen;
        if (s) seen = 1'b1;
      end
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [MW-1:0] act, input logic [MW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input string req, input logic [4:0] op, input logic vm,
      input logic [6:0] vst, input logic [MW-1:0] src, input logic [MW-1:0] en,
      input logic [MW-1:0] old, input logic [MW-1:0] exp, input logic exp_ill);
    @(negedge clk);
    op_sel_i = op; vm_i = vm; vstart_i = vst;
    src_mask_i = src; en_mask_i = en; old_dst_i = old;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    src_mask_i = ~src; old_dst_i = ~old;
    check({req, " done"}, MW'(done_o), MW'(1'b1));
    check({req, " result"}, result_o, exp);
    check({req, " illegal"}, MW'(illegal_o), MW'(exp_ill));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 reset result", result_o, '0);
    check("R10 reset done", MW'(done_o), '0);
    check("R10 reset illegal", MW'(illegal_o), '0);
    rst_n = 1'b1;

    // table walk: R2 R3 R4 R5 R6
    for (int k = 0; k < NVEC; k++) begin
      run("R2/R3/R4/R5/R6 table", TBL[k].op, TBL[k].vm, 7'd0, TBL[k].src, TBL[k].en,
          TBL[k].old, ref_dst(TBL[k].op, TBL[k].vm, TBL[k].src, TBL[k].en, TBL[k].old), 1'b0);
    end

    // R10: done low and result held on the cycle after the pulse
    @(negedge clk);
    check("R10 done drops", MW'(done_o), '0);
    check("R10 result held", result_o,
          ref_dst(TBL[NVEC-1].op, TBL[NVEC-1].vm, TBL[NVEC-1].src, TBL[NVEC-1].en, TBL[NVEC-1].old));

    // R9: no active set bit
    run("R9 before clear", 5'd1, 1'b1, 7'd0, 32'hAAAA_AAAA, '0, '0, 32'h5555_5555, 1'b0);
    run("R9 incl clear",   5'd3, 1'b1, 7'd0, '0, '0, 32'hAAAA_AAAA, 32'hFFFF_FFFF, 1'b0);
    run("R9 only clear",   5'd2, 1'b1, 7'd0, '0, '0, 32'hFFFF_FFFF, 32'hAAAA_AAAA, 1'b0);

    // R7: only the last element is set
    run("R7 last incl", 5'd3, 1'b1, 7'd0, 32'h4000_0000, '0, '0, 32'h5555_5555, 1'b0);
    run("R7 last only", 5'd2, 1'b1, 7'd0, 32'h4000_0000, '0, '0, 32'h4000_0000, 1'b0);
    run("R7 last before", 5'd1, 1'b1, 7'd0, 32'h4000_0000, '0, '0, 32'h1555_5555, 1'b0);

    // R5: masked-off set bit at element 0 is skipped; element 1 becomes first
    run("R5 skip inactive", 5'd2, 1'b0, 7'd0, 32'h0000_0005, 32'h0000_0004,
        32'h0000_0001, 32'h0000_0005, 1'b0);

    // R8: nonzero start index
    run("R8 vstart", 5'd1, 1'b1, 7'd3, 32'h0000_0010, '0, 32'h1234_5678, 32'h1234_5678, 1'b1);
    // R1: unknown codes rejected
    run("R1 code0", 5'd0, 1'b1, 7'd0, 32'h0000_0010, '0, 32'h8765_4321, 32'h8765_4321, 1'b1);
    run("R1 code4", 5'd4, 1'b1, 7'd0, 32'h0000_0010, '0, 32'hCAFE_F00D, 32'hCAFE_F00D, 1'b1);

    // R1 R2 R3 R4 R5: random masks over all codes and both vm values
    for (int k = 0; k < 240; k++) begin
      logic [4:0] op;
      logic vm;
      logic [MW-1:0] s, e, o;
      op = 5'(1 + (k % 3));
      vm = k[2];
      s = $urandom & $urandom;
      e = $urandom;
      o = $urandom;
      run("R1/R2/R3/R4/R5 random", op, vm, 7'd0, s, e, o, ref_dst(op, vm, s, e, o), 1'b0);
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule